// File: doc/BRIEF.md
# Lockstep Fault Injection Controller

This block runs two identical copies of a small register pipeline in lockstep and feeds both from one workload memory, one input vector per clock cycle. One copy serves as the golden reference. The other is the faulty copy. At a programmed workload cycle the controller inverts exactly one stored bit of the faulty copy. The bit is chosen by a register index. From the following cycle on, the controller compares the outputs of the two copies on every cycle.

A run starts with a single-cycle pulse on `start`. The controller clears both copies together, so that every run starts from identical state. It then walks through the workload. The run ends when the first mismatch is seen or when the workload is used up. At the end the block reports three results: whether damage occurred, the latency from injection to the first difference, and the lowest output group that differed. The results stay on the ports until the next run begins.

The design under test is built inside the block. It is a pipeline of `STAGES` registers, each `W` bits wide. Stage 0 captures the workload vector. Each later stage stores `x ^ (x << 1)` of the stage before it. The output is the last stage. That output is divided into `GROUPS` equal groups for reporting.

Top module: `lfi_lockstep_top`

## Requirements
- R1: After reset the following outputs are 0: `busy`, `done`, `damage`, `latency`, `fail_group` and `wl_addr`.
- R2: A `start` pulse is accepted only while the block is idle or done. It clears both copies and the previous results. From the next cycle `busy` is high, and in run cycle n the block presents `wl_addr` = n, one vector per cycle. A `start` pulse while `busy` is high is ignored.
- R3: Both copies receive the same vector in each cycle. Without an effective flip, their outputs never differ, and the run reports no damage.
- R4: Injection index i selects stage i / W, bit i % W. With T = `inj_cycle`, the selected bit of the faulty copy is stored inverted at the end of run cycle T. An index of W*STAGES or more flips nothing.
- R5: Each copy's stage 0 loads the vector. Stage k (k ≥ 1) loads s ^ (s << 1), where s is stage k-1. The output is stage STAGES-1. A flip in stage k therefore first reaches the output STAGES-k cycles after cycle T.
- R6: Outputs are compared in every run cycle after T. When the first mismatch is seen in cycle c < `wl_len`, `done` rises in the next cycle with `damage`=1 and `latency` = c - T. A flip in the last stage gives a latency of 1.
- R7: `fail_group` reports the lowest index g whose output bits g*W/GROUPS up to (g+1)*W/GROUPS-1 differed in the first mismatching cycle.
- R8: If there is no mismatch in cycles 0 to `wl_len`-1, `busy` stays high for `wl_len`+1 cycles. The run then ends with `damage`=0, `latency`=0 and `fail_group`=0. This includes the cases T ≥ `wl_len` and `wl_len`=0. On damage, `busy` is high for c+1 cycles.
- R9: `done` and the results hold steady until the next accepted `start`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Shared clock of the controller and both copies |
| rst_n | input | 1 | Asynchronous active-low reset |
| start | input | 1 | Single-cycle run request |
| inj_cycle | input | CW | Workload cycle T at whose end the flip is stored |
| inj_index | input | IW | Register bit index in the faulty copy |
| wl_len | input | CW | Number of workload vectors |
| wl_addr | output | CW | Workload memory read address (current run cycle) |
| wl_data | input | W | Workload vector read at `wl_addr` |
| busy | output | 1 | A run is in progress |
| done | output | 1 | A run has finished and the results are valid |
| damage | output | 1 | An output mismatch was detected |
| latency | output | CW | Cycles from injection to the first mismatch |
| fail_group | output | GIW | Lowest output group that differed |

## Verification
Random runs draw the injection cycle, the index and the workload length, and fill the workload memory with random vectors. Each run is compared against the latency and group predicted from the stage and bit of the index. Because the data is random, the check shows that detection does not depend on the data the workload carries.

Directed runs cover the following boundaries:
- a flip in the last stage, which tells apart a latency that counts from the flip cycle and one that counts from the cycle after it;
- a top-bit flip, for the highest group;
- a first mismatch in the final workload cycle against one cycle beyond it, which exposes an off-by-one at the end of the run;
- an out-of-range index, which shows that the copies stay equal;
- an injection after the workload ends and an empty workload;
- a stray `start` pulse in the middle of a run.

// File: rtl/lfi_pkg.sv
package lfi_pkg;

  typedef enum logic [2:0] {
    ST_IDLE    = 3'd0,
    ST_RUN_PRE = 3'd1,
    ST_INJECT  = 3'd2,
    ST_OBSERVE = 3'd3,
    ST_DONE    = 3'd4
  } lfi_state_e;

  // Index of the lowest set bit, 0 when none is set.
  function automatic int unsigned lowest_set(input logic [63:0] v);
    int unsigned r;
    r = 0;
    for (int i = 63; i >= 0; i--) begin
      if (v[i]) r = i;
    end
    return r;
  endfunction

endpackage

// File: rtl/lfi_dut_pipe.sv
module lfi_dut_pipe #(
  parameter int W      = 8,
  parameter int STAGES = 4,
  localparam int NBITS = W * STAGES
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             clr,
  input  logic             en,
  input  logic [W-1:0]     din,
  input  logic [NBITS-1:0] flip,
  output logic [W-1:0]     dout
);

  // Stage transform: each bit XOR its lower neighbour.
  function automatic logic [W-1:0] mix(input logic [W-1:0] x);
    return x ^ (x << 1);
  endfunction

  logic [STAGES-1:0][W-1:0] stg_q;
  logic [STAGES-1:0][W-1:0] stg_d;

  assign stg_d[0] = din;

  genvar k;
  generate
    for (k = 1; k < STAGES; k++) begin : g_stage
      assign stg_d[k] = mix(stg_q[k-1]);
    end
  endgenerate

  // The flip vector is laid out as stage k, bit b = index k*W+b.
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      stg_q <= '0;
    else if (clr)    stg_q <= '0;
    else if (en)     stg_q <= stg_d ^ flip;
  end

  assign dout = stg_q[STAGES-1];

endmodule

// File: rtl/lfi_cmp.sv
module lfi_cmp #(
  parameter int W      = 8,
  parameter int GROUPS = 4,
  localparam int GW    = W / GROUPS,
  localparam int GIW   = (GROUPS > 1) ? $clog2(GROUPS) : 1
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic [W-1:0]   gold,
  input  logic [W-1:0]   faulty,
  output logic           any_diff,
  output logic [GIW-1:0] first_grp
);

  logic [GROUPS-1:0] grp_diff;
  logic [W-1:0]      diff;

  assign diff = gold ^ faulty;

  genvar g;
  generate
    for (g = 0; g < GROUPS; g++) begin : g_grp
      assign grp_diff[g] = |diff[g*GW +: GW];
    end
  endgenerate

  assign any_diff  = |grp_diff;
  assign first_grp = GIW'(lfi_pkg::lowest_set(64'(grp_diff)));

  // The reported group must itself be one that differs.
  AST_GROUP_DIFFERS: assert property (@(posedge clk) disable iff (!rst_n)
    any_diff |-> grp_diff[first_grp]); // R7

endmodule

// File: rtl/lfi_ctrl.sv
module lfi_ctrl
  import lfi_pkg::*;
#(
  parameter int CW    = 12,
  parameter int NBITS = 32,
  parameter int IW    = 6,
  parameter int GIW   = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             start,
  input  logic [CW-1:0]    inj_cycle,
  input  logic [IW-1:0]    inj_index,
  input  logic [CW-1:0]    wl_len,
  input  logic             mismatch,
  input  logic [GIW-1:0]   first_grp,
  output lfi_state_e       state,
  output logic             running,
  output logic             copy_clr,
  output logic             copy_en,
  output logic [NBITS-1:0] flip_vec,
  output logic [CW-1:0]    wl_addr,
  output logic             busy,
  output logic             done,
  output logic             damage,
  output logic [CW-1:0]    latency,
  output logic [GIW-1:0]   fail_group
);

  function automatic lfi_state_e run_state(input logic [CW-1:0] c,
                                           input logic [CW-1:0] t);
    if (c < t)       return ST_RUN_PRE;
    else if (c == t) return ST_INJECT;
    else             return ST_OBSERVE;
  endfunction

  function automatic logic [NBITS-1:0] flip_mask(input logic [IW-1:0] i);
    logic [NBITS-1:0] m;
    for (int b = 0; b < NBITS; b++) m[b] = (i == IW'(b));
    return m;
  endfunction

  function automatic logic [CW-1:0] lat_of(input logic [CW-1:0] c,
                                           input logic [CW-1:0] t);
    return c - t;
  endfunction

  logic [CW-1:0] cyc_q;
  logic [CW-1:0] t_q;
  logic [CW-1:0] len_q;
  logic [IW-1:0] idx_q;
  logic          at_end;
  logic          hit;
  logic          accept;

  assign running  = (state == ST_RUN_PRE) || (state == ST_INJECT) ||
                    (state == ST_OBSERVE);
  assign at_end   = running && (cyc_q >= len_q);
  assign hit      = (state == ST_OBSERVE) && mismatch && !at_end;
  assign accept   = start && ((state == ST_IDLE) || (state == ST_DONE));
  assign copy_clr = accept;
  assign copy_en  = running && !at_end;
  assign flip_vec = ((state == ST_INJECT) && !at_end) ? flip_mask(idx_q) : '0;
  assign wl_addr  = cyc_q;
  assign busy     = running;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state      <= ST_IDLE;
      cyc_q      <= '0;
      t_q        <= '0;
      len_q      <= '0;
      idx_q      <= '0;
      done       <= 1'b0;
      damage     <= 1'b0;
      latency    <= '0;
      fail_group <= '0;
    end else if (accept) begin
      t_q        <= inj_cycle;
      len_q      <= wl_len;
      idx_q      <= inj_index;
      cyc_q      <= '0;
      state      <= run_state('0, inj_cycle);
      done       <= 1'b0;
      damage     <= 1'b0;
      latency    <= '0;
      fail_group <= '0;
    end else if (running) begin
      if (at_end) begin
        state <= ST_DONE;
        done  <= 1'b1;
      end else if (hit) begin
        state      <= ST_DONE;
        done       <= 1'b1;
        damage     <= 1'b1;
        latency    <= lat_of(cyc_q, t_q);
        fail_group <= first_grp;
      end else begin
        cyc_q <= cyc_q + CW'(1);
        state <= run_state(cyc_q + CW'(1), t_q);
      end
    end
  end

  AST_DONE_NOT_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
    !(done && busy)); // R2

  AST_ADDR_STEP: assert property (@(posedge clk) disable iff (!rst_n)
    (running && !at_end && !hit && !start) |=> (wl_addr == $past(wl_addr) + CW'(1))); // R2

  AST_DAMAGE_LATENCY: assert property (@(posedge clk) disable iff (!rst_n)
    (done && damage) |-> (latency != '0)); // R6

  AST_CLEAN_RESULT: assert property (@(posedge clk) disable iff (!rst_n)
    (done && !damage) |-> (latency == '0 && fail_group == '0)); // R8

  AST_RESULT_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (done && !start) |=> (done && $stable(latency) && $stable(damage) &&
                          $stable(fail_group))); // R9

endmodule

// File: rtl/lfi_lockstep_top.sv
module lfi_lockstep_top
  import lfi_pkg::*;
#(
  parameter int W      = 8,
  parameter int STAGES = 4,
  parameter int GROUPS = 4,
  parameter int CW     = 12,
  localparam int NBITS = W * STAGES,
  localparam int IW    = $clog2(NBITS) + 1,
  localparam int GIW   = (GROUPS > 1) ? $clog2(GROUPS) : 1
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic           start,
  input  logic [CW-1:0]  inj_cycle,
  input  logic [IW-1:0]  inj_index,
  input  logic [CW-1:0]  wl_len,
  output logic [CW-1:0]  wl_addr,
  input  logic [W-1:0]   wl_data,
  output logic           busy,
  output logic           done,
  output logic           damage,
  output logic [CW-1:0]  latency,
  output logic [GIW-1:0] fail_group
);

  lfi_state_e       state;
  logic             running;
  logic             copy_clr;
  logic             copy_en;
  logic [NBITS-1:0] flip_vec;
  logic [W-1:0]     gold_out;
  logic [W-1:0]     faulty_out;
  logic             mismatch;
  logic [GIW-1:0]   first_grp;

  lfi_ctrl #(.CW(CW), .NBITS(NBITS), .IW(IW), .GIW(GIW)) u_ctrl (
    .clk(clk), .rst_n(rst_n), .start(start), .inj_cycle(inj_cycle),
    .inj_index(inj_index), .wl_len(wl_len), .mismatch(mismatch),
    .first_grp(first_grp), .state(state), .running(running),
    .copy_clr(copy_clr), .copy_en(copy_en), .flip_vec(flip_vec),
    .wl_addr(wl_addr), .busy(busy), .done(done), .damage(damage),
    .latency(latency), .fail_group(fail_group)
  );

  lfi_dut_pipe #(.W(W), .STAGES(STAGES)) u_gold (
    .clk(clk), .rst_n(rst_n), .clr(copy_clr), .en(copy_en),
    .din(wl_data), .flip('0), .dout(gold_out)
  );

  lfi_dut_pipe #(.W(W), .STAGES(STAGES)) u_faulty (
    .clk(clk), .rst_n(rst_n), .clr(copy_clr), .en(copy_en),
    .din(wl_data), .flip(flip_vec), .dout(faulty_out)
  );

  lfi_cmp #(.W(W), .GROUPS(GROUPS)) u_cmp (
    .clk(clk), .rst_n(rst_n), .gold(gold_out), .faulty(faulty_out),
    .any_diff(mismatch), .first_grp(first_grp)
  );

  AST_NO_EARLY_MISMATCH: assert property (@(posedge clk) disable iff (!rst_n)
    (state == ST_RUN_PRE || state == ST_INJECT) |-> !mismatch); // R3

  AST_SINGLE_FLIP: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(flip_vec)); // R4

  AST_FLIP_ONLY_AT_T: assert property (@(posedge clk) disable iff (!rst_n)
    (flip_vec != '0) |-> (state == ST_INJECT && busy)); // R4

endmodule

// File: tb/tb_lfi_lockstep_top.sv
module tb_lfi_lockstep_top;

  localparam int CLK_PERIOD = 10;
  localparam int W      = 8;
  localparam int S      = 4;
  localparam int G      = 4;
  localparam int CW     = 12;
  localparam int NB     = W * S;
  localparam int IW     = $clog2(NB) + 1;
  localparam int GIW    = 2;

  logic           clk = 1'b0;
  logic           rst_n = 1'b0;
  logic           start = 1'b0;
  logic [CW-1:0]  inj_cycle = '0;
  logic [IW-1:0]  inj_index = '0;
  logic [CW-1:0]  wl_len = '0;
  logic [CW-1:0]  wl_addr;
  logic [W-1:0]   wl_data;
  logic           busy, done, damage;
  logic [CW-1:0]  latency;
  logic [GIW-1:0] fail_group;
  logic [W-1:0]   mem [0:255];

  int n_checks = 0;
  int n_fail   = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  assign wl_data = mem[wl_addr[7:0]];

  lfi_lockstep_top #(.W(W), .STAGES(S), .GROUPS(G), .CW(CW)) dut (
    .clk(clk), .rst_n(rst_n), .start(start), .inj_cycle(inj_cycle),
    .inj_index(inj_index), .wl_len(wl_len), .wl_addr(wl_addr),
    .wl_data(wl_data), .busy(busy), .done(done), .damage(damage),
    .latency(latency), .fail_group(fail_group)
  );

  task automatic chk(input bit ok, input string req, input string what,
                     input int act, input int exp);
    n_checks++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
    end
  endtask

  // Expected outcome restated from the requirements.
  function automatic bit exp_damage(int t, int idx, int len);
    if (idx >= NB || t >= len) return 1'b0;
    return (t + S - idx / W) <= len - 1;
  endfunction
  function automatic int exp_latency(int t, int idx, int len);
    return exp_damage(t, idx, len) ? S - idx / W : 0;
  endfunction
  function automatic int exp_group(int t, int idx, int len);
    return exp_damage(t, idx, len) ? (idx % W) / (W / G) : 0;
  endfunction
  function automatic int exp_busy(int t, int idx, int len);
    return exp_damage(t, idx, len) ? t + S - idx / W + 1 : len + 1;
  endfunction

  task automatic run_case(input int t, input int idx, input int len,
                          input bit poke, input string tag);
    int cnt;
    bit addr_ok;
    logic [CW-1:0] lat_h;
    for (int a = 0; a < 256; a++) mem[a] = W'($urandom);
    inj_cycle = CW'(t);
    inj_index = IW'(idx);
    wl_len    = CW'(len);
    start     = 1'b1;
    @(negedge clk);
    start   = 1'b0;
    cnt     = 0;
    addr_ok = 1'b1;
    while (busy && cnt < 2000) begin
      if (int'(wl_addr) != cnt) addr_ok = 1'b0;
      start = (poke && cnt == 1);
      cnt++;
      @(negedge clk);
    end
    start = 1'b0;
    chk(addr_ok, "R2", {tag, " address follows cycle"}, addr_ok, 1);
    chk(cnt == exp_busy(t, idx, len), "R8",
        {tag, " busy cycles"}, cnt, exp_busy(t, idx, len));
    chk(done == 1'b1, "R6", {tag, " done"}, done, 1);
    chk(damage == exp_damage(t, idx, len), "R6",
        {tag, " damage"}, damage, exp_damage(t, idx, len));
    chk(int'(latency) == exp_latency(t, idx, len), "R5",
        {tag, " latency"}, latency, exp_latency(t, idx, len));
    chk(int'(fail_group) == exp_group(t, idx, len), "R7",
        {tag, " group"}, fail_group, exp_group(t, idx, len));
    lat_h = latency;
    inj_cycle = '0;
    inj_index = '0;
    repeat (2) @(negedge clk);
    chk(done && latency == lat_h, "R9", {tag, " result held"}, latency, lat_h);
  endtask

  initial begin
    #(CLK_PERIOD * 150000);
    n_checks++;
    n_fail++;
    $display("FAIL watchdog: actual 0 expected 1 (run completed)");
    $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
    $finish;
  end

  initial begin
    void'($urandom(32'd24681));
    for (int a = 0; a < 256; a++) mem[a] = '0;
    repeat (3) @(negedge clk);
    // R1: reset state
    chk(!busy && !done && !damage, "R1", "flags at reset", {busy, done, damage}, 0);
    chk(latency == '0 && fail_group == '0 && wl_addr == '0, "R1",
        "values at reset", latency, 0);
    rst_n = 1'b1;
    @(negedge clk);

    // Directed corners
    run_case(0, 24, 10, 1'b0, "R6 last stage T0");      // latency 1
    run_case(5, 31, 20, 1'b0, "R7 top bit");            // group 3
    run_case(3, 0, 8, 1'b0, "R5 stage0 last cycle");    // mismatch at len-1
    run_case(3, 0, 7, 1'b0, "R8 stage0 one past end");  // no damage
    run_case(4, 40, 30, 1'b0, "R4 R3 index out of range");
    run_case(20, 9, 10, 1'b0, "R8 inject after end");
    run_case(0, 5, 0, 1'b0, "R8 empty workload");
    run_case(4, 8, 30, 1'b1, "R2 stray start");
    run_case(2, 13, 25, 1'b0, "R4 stage1 bit5");

    // Random runs
    for (int i = 0; i < 40; i++) begin
      int t, idx, len;
      t   = int'($urandom % 60);
      len = int'($urandom % 64);
      idx = int'($urandom % 40);
      run_case(t, idx, len, 1'b0, "random");
    end

    $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
    $finish;
  end

endmodule